// File: doc/BRIEF.md
# Dual-Clock Word FIFO

This block carries 16-bit words from one clock domain into a second, unrelated clock domain. It holds up to eight words, and words come out in the order they went in. A producer in the write domain pushes a word by raising its enable while the full flag is low. A consumer in the read domain pops a word by raising its enable while the empty flag is low, and it finds that word on a registered output right after the accepting edge.

Each side keeps its own pointer. The pointer goes to the other side in Gray code through a two-flop synchronizer. Each flag is registered in its own domain and is computed from the pointer value that will hold after the current edge. A flag therefore sets on the same edge that makes it true. It clears a bounded number of local edges after the other domain acts. The two synchronous resets are always raised and dropped together.

Top module: `xdom_word_fifo`

## Requirements
- R1: Words are read out in exactly the order they were accepted. The store holds 8 words of 16 bits, and no word is lost, duplicated or invented under any ratio of the two clocks.
- R2: A write is accepted on a rising `wrClk` edge only when `wrEn` is 1 and `wrFull` is 0. A write attempted while `wrFull` is 1 stores nothing, so a later drain returns only the eight earlier words.
- R3: A read is accepted on a rising `rdClk` edge only when `rdEn` is 1 and `rdEmpty` is 0. A read attempted while `rdEmpty` is 1 changes nothing, so the next word written is the next word read.
- R4: The word removed by an accepted read is on `rdData` straight after that `rdClk` edge.
- R5: `wrFull` is 1 right after the `wrClk` edge whose write takes the eighth slot, and it is 0 while fewer than eight words are held.
- R6: `rdEmpty` is 1 right after the `rdClk` edge whose read removes the last stored word, and it is 0 while the read side still holds words.
- R7: After a read frees a slot in a full FIFO, `wrFull` is 0 no later than the third `wrClk` rising edge after that read edge.
- R8: After a write into an empty FIFO, `rdEmpty` is 0 no later than the third `rdClk` rising edge after that write edge.
- R9: While the resets are high, no read or write is accepted. After release, `wrFull` is 0, `rdEmpty` is 1, and no word written before or during reset can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRst | input | 1 | Synchronous active-high reset, write domain |
| wrEn | input | 1 | Push request, sampled on rising `wrClk` |
| wrData | input | 16 | Word to push |
| wrFull | output | 1 | High when no further push can be taken |
| rdClk | input | 1 | Read-domain clock |
| rdRst | input | 1 | Synchronous active-high reset, read domain |
| rdEn | input | 1 | Pop request, sampled on rising `rdClk` |
| rdData | output | 16 | Word returned by the last accepted pop |
| rdEmpty | output | 1 | High when no stored word is available to pop |

## Verification
Directed fills and drains at a fixed clock ratio show the exact edge on which each flag sets. They also show that a push while full or a pop while empty leaves no trace in the later data. Single-word handoffs across an idle boundary count the local edges a flag takes to clear after the far side acts, which tells a correct two-stage crossing apart from a slower or stuck one. Concurrent streams are run with the read clock faster than, slower than and close to the write clock. These streams stress underflow, overflow and mixed pressure, and each popped word is compared with the producer's sequence. A mid-stream reset with requests held high shows that nothing is taken during reset and that nothing stale survives it.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  localparam int FIFO_DATA_W      = 16;
  localparam int FIFO_ADDR_W      = 3;
  localparam int FIFO_SYNC_STAGES = 2;

  // Strobes from pointer control into the storage datapath.
  typedef struct packed {
    logic wrStb;  // store wrData at wrAddr (write domain)
    logic rdStb;  // load rdData from rdAddr (read domain)
  } fifoStb_t;

endpackage

// File: rtl/xdom_sync2.sv
module xdom_sync2 #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/xdom_fifo_ctrl.sv
module xdom_fifo_ctrl
  import xdom_fifo_pkg::*;
#(
  parameter int ADDR_W      = FIFO_ADDR_W,
  parameter int SYNC_STAGES = FIFO_SYNC_STAGES,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  output logic              wrFull,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic              rdEmpty,
  output logic [ADDR_W-1:0] rdAddr,
  output fifoStb_t          stb,
  output logic [PTR_W-1:0]  wrPtrBin,
  output logic [PTR_W-1:0]  rdPtrBin,
  output logic [PTR_W-1:0]  rdSyncBin,
  output logic [PTR_W-1:0]  wrSyncBin
);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrPtrGray, rdPtrGray;
  logic [PTR_W-1:0] rdGraySync, wrGraySync;
  logic [PTR_W-1:0] wrBinNext, wrGrayNext, rdBinNext, rdGrayNext;
  logic             wrAccept, rdAccept, fullNext, emptyNext;

  // ---------------- write domain ----------------
  assign wrAccept   = wrEn & ~wrFull & ~wrRst;
  assign wrBinNext  = wrPtrBin + PTR_W'(wrAccept);
  assign wrGrayNext = toGray(wrBinNext);
  // Full: next pointer one lap ahead of the synchronized read pointer.
  assign fullNext   = (wrGrayNext == {~rdGraySync[PTR_W-1:PTR_W-2],
                                       rdGraySync[PTR_W-3:0]});

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
      wrFull    <= 1'b0;
    end else begin
      wrPtrBin  <= wrBinNext;
      wrPtrGray <= wrGrayNext;
      wrFull    <= fullNext;
    end
  end

  // ---------------- read domain ----------------
  assign rdAccept   = rdEn & ~rdEmpty & ~rdRst;
  assign rdBinNext  = rdPtrBin + PTR_W'(rdAccept);
  assign rdGrayNext = toGray(rdBinNext);
  assign emptyNext  = (rdGrayNext == wrGraySync);

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
      rdEmpty   <= 1'b1;
    end else begin
      rdPtrBin  <= rdBinNext;
      rdPtrGray <= rdGrayNext;
      rdEmpty   <= emptyNext;
    end
  end

  // ---------------- crossings ----------------
  xdom_sync2 #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk (wrClk),
    .rst (wrRst),
    .din (rdPtrGray),
    .dout(rdGraySync)
  );

  xdom_sync2 #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk (rdClk),
    .rst (rdRst),
    .din (wrPtrGray),
    .dout(wrGraySync)
  );

  assign rdSyncBin = fromGray(rdGraySync);
  assign wrSyncBin = fromGray(wrGraySync);

  assign wrAddr    = wrPtrBin[ADDR_W-1:0];
  assign rdAddr    = rdPtrBin[ADDR_W-1:0];
  assign stb.wrStb = wrAccept;
  assign stb.rdStb = rdAccept;

endmodule

// File: rtl/xdom_fifo_store.sv
module xdom_fifo_store
  import xdom_fifo_pkg::*;
#(
  parameter int DATA_W = FIFO_DATA_W,
  parameter int ADDR_W = FIFO_ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic [ADDR_W-1:0] rdAddr,
  input  fifoStb_t          stb,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/xdom_word_fifo.sv
module xdom_word_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int DATA_W      = FIFO_DATA_W,
  parameter int ADDR_W      = FIFO_ADDR_W,
  parameter int SYNC_STAGES = FIFO_SYNC_STAGES,
  localparam int PTR_W      = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);

  fifoStb_t          stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [PTR_W-1:0]  wrPtrBin, rdPtrBin, rdSyncBin, wrSyncBin;

  xdom_fifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk    (wrClk),
    .wrRst    (wrRst),
    .wrEn     (wrEn),
    .wrFull   (wrFull),
    .wrAddr   (wrAddr),
    .rdClk    (rdClk),
    .rdRst    (rdRst),
    .rdEn     (rdEn),
    .rdEmpty  (rdEmpty),
    .rdAddr   (rdAddr),
    .stb      (stb),
    .wrPtrBin (wrPtrBin),
    .rdPtrBin (rdPtrBin),
    .rdSyncBin(rdSyncBin),
    .wrSyncBin(wrSyncBin)
  );

  xdom_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk (wrClk),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdClk (rdClk),
    .rdRst (rdRst),
    .rdAddr(rdAddr),
    .stb   (stb),
    .rdData(rdData)
  );

endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter int PTR_W = 4,
  localparam int DEPTH = 1 << (PTR_W - 1)
) (
  input logic             wrClk,
  input logic             wrRst,
  input logic             wrEn,
  input logic             wrFull,
  input logic             rdClk,
  input logic             rdRst,
  input logic             rdEn,
  input logic             rdEmpty,
  input logic [PTR_W-1:0] wrPtrBin,
  input logic [PTR_W-1:0] rdPtrBin,
  input logic [PTR_W-1:0] rdSyncBin,
  input logic [PTR_W-1:0] wrSyncBin
);

  logic [PTR_W-1:0] wrSeenCount, rdSeenCount;
  assign wrSeenCount = wrPtrBin - rdSyncBin;
  assign rdSeenCount = wrSyncBin - rdPtrBin;

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrEn && !wrFull) |-> (wrSeenCount < PTR_W'(DEPTH)));  // R2

  AST_HOLD_WHEN_FULL: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrEn && wrFull) |=> $stable(wrPtrBin));  // R2

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEn && !rdEmpty) |-> (rdSeenCount != '0));  // R3

  AST_HOLD_WHEN_EMPTY: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEn && rdEmpty) |=> $stable(rdPtrBin));  // R3

  AST_FULL_ON_LAST: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrEn && !wrFull && wrSeenCount == PTR_W'(DEPTH - 1)) |=> wrFull);  // R5

  AST_EMPTY_ON_LAST: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEn && !rdEmpty && rdSeenCount == PTR_W'(1)) |=> rdEmpty);  // R6

  AST_RESET_FULL_LOW: assert property (@(posedge wrClk)
    wrRst |=> !wrFull);  // R9

  AST_RESET_EMPTY_HIGH: assert property (@(posedge rdClk)
    rdRst |=> rdEmpty);  // R9

endmodule

bind xdom_word_fifo xdom_fifo_chk #(.PTR_W(PTR_W)) u_chk (
  .wrClk    (wrClk),
  .wrRst    (wrRst),
  .wrEn     (wrEn),
  .wrFull   (wrFull),
  .rdClk    (rdClk),
  .rdRst    (rdRst),
  .rdEn     (rdEn),
  .rdEmpty  (rdEmpty),
  .wrPtrBin (wrPtrBin),
  .rdPtrBin (rdPtrBin),
  .rdSyncBin(rdSyncBin),
  .wrSyncBin(wrSyncBin)
);

// File: tb/xdom_word_fifo_tb_top.sv
`timescale 1ns/100ps
module xdom_word_fifo_tb_top;

  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        wrRst, rdRst, wrEn, rdEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        wrFull, rdEmpty;
  int          rdHalf = 3;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  xdom_word_fifo dut_i (
    .wrClk  (wrClk),
    .wrRst  (wrRst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .wrFull (wrFull),
    .rdClk  (rdClk),
    .rdRst  (rdRst),
    .rdEn   (rdEn),
    .rdData (rdData),
    .rdEmpty(rdEmpty)
  );

  // 250 MHz write clock: rising edges on whole even nanoseconds.
  always #2 wrClk = ~wrClk;
  // Read clock toggles on half-nanosecond offsets, never on a write edge.
  initial begin
    #0.5;
    forever #(rdHalf) rdClk = ~rdClk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pattern(input int seed, input int i);
    return 16'(seed) ^ 16'(i * 16'h01F3) ^ 16'(i << 9);
  endfunction

  task automatic pushOne(input logic [15:0] d);
    @(posedge wrClk); #0.3;
    wrEn = 1'b1; wrData = d;
    @(posedge wrClk); #0.3;
    wrEn = 1'b0;
  endtask

  task automatic popOne(output logic [15:0] d);
    @(posedge rdClk); #0.2;
    rdEn = 1'b1;
    @(posedge rdClk); #0.2;
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic doReset();
    @(posedge wrClk); #0.3;
    wrRst = 1'b1; rdRst = 1'b1;
    repeat (8) @(posedge rdClk);
    @(posedge wrClk); #0.3;
    wrRst = 1'b0; rdRst = 1'b0;
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic testResetState();
    #0.2;
    chk(wrFull == 1'b0, "R9 full low after reset", wrFull, 0);
    chk(rdEmpty == 1'b1, "R9 empty high after reset", rdEmpty, 1);
    repeat (6) @(posedge rdClk);
    #0.2;
    chk(rdEmpty == 1'b1, "R9 empty stays high with no writes", rdEmpty, 1);
  endtask

  task automatic testFillDrain();
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      pushOne(pattern(16'hA500, i));
      if (i < 7) chk(wrFull == 1'b0, "R5 full low below capacity", wrFull, 0);
      else       chk(wrFull == 1'b1, "R5 full high after eighth write", wrFull, 1);
    end
    // Push attempts while full must not store anything (R2).
    @(posedge wrClk); #0.3;
    wrEn = 1'b1; wrData = 16'hDEAD;
    repeat (3) @(posedge wrClk);
    #0.3; wrEn = 1'b0;
    chk(wrFull == 1'b1, "R2 full stays set after refused write", wrFull, 1);
    repeat (6) @(posedge rdClk);
    for (int i = 0; i < 8; i++) begin
      popOne(d);
      chk(d == pattern(16'hA500, i), "R1 R4 drain order", d, pattern(16'hA500, i));
      if (i < 7) chk(rdEmpty == 1'b0, "R6 empty low while words remain", rdEmpty, 0);
      else       chk(rdEmpty == 1'b1, "R6 empty high after last read", rdEmpty, 1);
    end
    repeat (8) @(posedge rdClk);
    #0.2;
    chk(rdEmpty == 1'b1, "R2 no ninth word stored", rdEmpty, 1);
    // Pop attempts while empty must change nothing (R3).
    @(posedge rdClk); #0.2;
    rdEn = 1'b1;
    repeat (3) @(posedge rdClk);
    #0.2; rdEn = 1'b0;
    chk(rdEmpty == 1'b1, "R3 empty holds under refused reads", rdEmpty, 1);
    pushOne(16'h1234);
    repeat (5) @(posedge rdClk);
    popOne(d);
    chk(d == 16'h1234, "R3 next read returns next write", d, 16'h1234);
    chk(rdEmpty == 1'b1, "R6 empty again after single word", rdEmpty, 1);
  endtask

  task automatic testFlagLatency();
    logic [15:0] d;
    int n;
    for (int i = 0; i < 8; i++) pushOne(pattern(16'h3C00, i));
    chk(wrFull == 1'b1, "R5 full before latency read", wrFull, 1);
    repeat (10) @(posedge wrClk);
    @(posedge rdClk); #0.2;
    rdEn = 1'b1;
    @(posedge rdClk); #0.2;
    rdEn = 1'b0;
    d = rdData;
    chk(d == pattern(16'h3C00, 0), "R4 data right after read edge", d, pattern(16'h3C00, 0));
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge wrClk); #0.3;
      n++;
      if (!wrFull) break;
    end
    chk(n <= 3 && !wrFull, "R7 full clears within three write edges", n, 3);
    for (int i = 1; i < 8; i++) begin
      popOne(d);
      chk(d == pattern(16'h3C00, i), "R1 order after latency read", d, pattern(16'h3C00, i));
    end
    chk(rdEmpty == 1'b1, "R6 empty after latency drain", rdEmpty, 1);
    repeat (6) @(posedge wrClk);
    pushOne(16'h0F0F);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge rdClk); #0.2;
      n++;
      if (!rdEmpty) break;
    end
    chk(n <= 3 && !rdEmpty, "R8 empty clears within three read edges", n, 3);
    popOne(d);
    chk(d == 16'h0F0F, "R4 single word returned", d, 16'h0F0F);
  endtask

  task automatic testStream(input int half, input int seed, input int count);
    int errs = 0;
    rdHalf = half;
    repeat (4) @(posedge rdClk);
    fork
      begin : writer
        int i = 0;
        @(posedge wrClk); #0.3;
        while (i < count) begin
          if (!wrFull) begin
            wrEn = 1'b1; wrData = pattern(seed, i); i++;
          end else begin
            wrEn = 1'b0;
          end
          @(posedge wrClk); #0.3;
        end
        wrEn = 1'b0;
      end
      begin : reader
        int j = 0;
        @(posedge rdClk); #0.2;
        while (j < count) begin
          if (!rdEmpty) begin
            rdEn = 1'b1;
            @(posedge rdClk); #0.2;
            if (rdData != pattern(seed, j)) errs++;
            chk(rdData == pattern(seed, j), "R1 stream order", rdData, pattern(seed, j));
            j++;
          end else begin
            rdEn = 1'b0;
            @(posedge rdClk); #0.2;
          end
        end
        rdEn = 1'b0;
      end
    join
    repeat (6) @(posedge rdClk);
    repeat (4) @(posedge wrClk);
    #0.3;
    chk(rdEmpty == 1'b1, "R1 nothing left after stream", rdEmpty, 1);
    chk(wrFull == 1'b0, "R1 full clear after stream", wrFull, 0);
    if (errs != 0) $display("stream half=%0d had %0d mismatches", half, errs);
  endtask

  task automatic testMidReset();
    logic [15:0] d;
    for (int i = 0; i < 3; i++) pushOne(pattern(16'h7700, i));
    repeat (6) @(posedge rdClk);
    @(posedge wrClk); #0.3;
    wrRst = 1'b1; rdRst = 1'b1;
    wrEn = 1'b1; wrData = 16'hBEEF; rdEn = 1'b1;
    repeat (8) @(posedge rdClk);
    @(posedge wrClk); #0.3;
    wrRst = 1'b0; rdRst = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    #0.2;
    chk(wrFull == 1'b0, "R9 full low after mid reset", wrFull, 0);
    chk(rdEmpty == 1'b1, "R9 empty high after mid reset", rdEmpty, 1);
    repeat (8) @(posedge rdClk);
    #0.2;
    chk(rdEmpty == 1'b1, "R9 no stale or reset-time word", rdEmpty, 1);
    pushOne(16'h5A5A);
    repeat (5) @(posedge rdClk);
    popOne(d);
    chk(d == 16'h5A5A, "R9 first word after reset", d, 16'h5A5A);
  endtask

  initial begin
    wrRst = 1'b1; rdRst = 1'b1;
    wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    repeat (8) @(posedge rdClk);
    @(posedge wrClk); #0.3;
    wrRst = 1'b0; rdRst = 1'b0;
    testResetState();
    testFillDrain();
    testFlagLatency();
    testStream(1, 16'h1100, 40);   // read clock faster
    testStream(5, 16'h2200, 40);   // read clock slower
    testStream(3, 16'h4400, 40);   // comparable rates
    rdHalf = 3;
    testMidReset();
    doReset();
    testResetState();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule